// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

A purely combinational arithmetic and logic unit for a 16-bit integer datapath. Each cycle it takes a destination operand, a source operand, the incoming carry flag, a 4-bit operation code and a size select. It returns the result, a write-enable that tells the register stage whether to store that result, and six status flags together with a per-flag update mask. The surrounding pipeline merges the flag values into its flag register only where the mask bit is set. Flags whose mask bit is clear keep their old value.

The operations are add, add-with-carry, subtract, subtract-with-borrow, compare, AND, OR, XOR, test, NOT, negate, increment and decrement. Each one works either on the low byte or on the full word. Compare and test exist only for their flags, so they never assert the write-enable. The block has no clock, no reset, no valid/ready handshake and no internal state. Operand fetch, addressing and the register file belong to neighbouring stages.

Flag vector bit positions, used by both `flags_o` and `flag_upd_o`: bit 0 carry (CF), bit 1 parity (PF), bit 2 auxiliary carry (AF), bit 3 zero (ZF), bit 4 sign (SF), bit 5 overflow (OF).

Top module: `bw_alu`

## Requirements
- R1: `word_i`=1 selects 16-bit operation and `word_i`=0 selects 8-bit operation. In byte mode only bits 7:0 of the operands are used, `res_o[15:8]` is zero, and the flags describe the low byte. Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 TEST, 9 NOT, 10 NEG, 11 INC, 12 DEC.
- R2: ADD gives dst+src and ADC gives dst+src+`cf_i`. CF is the carry out of the operand's top bit. All six flags are updated (mask 6'h3F) and `wr_en_o`=1.
- R3: SUB gives dst−src and SBB gives dst−src−`cf_i`. CF is 1 exactly when a borrow occurs, that is, when the unsigned subtrahend, including any borrow in, exceeds dst. Mask 6'h3F, `wr_en_o`=1.
- R4: CMP produces the same flags and mask as SUB, but `wr_en_o`=0.
- R5: AND, OR and XOR give the bitwise result with `wr_en_o`=1. CF=OF=0; PF, SF and ZF are updated; AF is not updated (mask 6'h3B).
- R6: TEST produces the flags and mask of AND, with `wr_en_o`=0.
- R7: NOT gives the one's complement of dst with `wr_en_o`=1 and updates no flag (mask 0).
- R8: NEG gives 0−dst with all six flags updated. CF=1 exactly when dst is non-zero.
- R9: INC gives dst+1 and DEC gives dst−1. Every flag except CF is updated (mask 6'h3E).
- R10: PF=1 when bits 7:0 of the result hold an even number of ones, in both sizes.
- R11: AF is the carry out of bit 3 (the borrow into bit 4 on subtraction). OF is signed overflow, taken at bit 7 in byte mode and at bit 15 in word mode.
- R12: SF is the top bit of the selected size, and ZF=1 when the selected-size result is zero.
- R13: Codes 13 to 15 give `res_o`=0, `wr_en_o`=0 and mask 0.
- R14: Every `flags_o` bit whose mask bit is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand (first operand) |
| src_i | input | 16 | Source operand (second operand) |
| cf_i | input | 1 | Incoming carry/borrow flag |
| op_i | input | 4 | Operation code (see R1) |
| word_i | input | 1 | 1 = word, 0 = byte |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 6 | Flag values {OF,SF,ZF,AF,PF,CF} |
| flag_upd_o | output | 6 | Flag update mask, same bit order |

## Verification
The block holds no state, so any fault in the decode or in the carry chain appears at the ports in the same cycle that the offending operand pair is applied. Because of this, the sweep compares result, write-enable, every flag and the mask on every vector. A wrong carry-in inversion on subtraction shows up as a wrong CF or result only for certain operand pairs. A wrong size multiplexer shows up as stray upper-byte bits or as a wrong SF, ZF or OF near 8'h7F/8'h80. For these reasons the byte sweep covers every destination value against a set of boundary sources, with both carry-in values.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_N = 6;

  // flag vector bit positions
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;

  localparam logic [FLAG_N-1:0] UPD_ALL   = 6'h3F;
  localparam logic [FLAG_N-1:0] UPD_NO_CF = 6'h3E;
  localparam logic [FLAG_N-1:0] UPD_LOGIC = 6'h3B;
  localparam logic [FLAG_N-1:0] UPD_NONE  = 6'h00;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_NOT  = 4'd9,
    OP_NEG  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
  parameter int WID     = 8,
  parameter int AUX_BIT = 4
) (
  input  logic [WID-1:0] a,
  input  logic [WID-1:0] b,
  input  logic           sub,
  input  logic           cin,     // carry in (add) or borrow in (sub)
  output logic [WID-1:0] sum,
  output logic           cb_out,  // carry out (add) or borrow out (sub)
  output logic           ovf,
  output logic           aux
);

  logic [WID-1:0] b_eff;
  logic           c_eff;
  logic [WID:0]   total;

  always_comb begin
    b_eff  = sub ? ~b : b;
    c_eff  = sub ? ~cin : cin;
    total  = {1'b0, a} + {1'b0, b_eff} + {{WID{1'b0}}, c_eff};
    sum    = total[WID-1:0];
    cb_out = sub ? ~total[WID] : total[WID];
    ovf    = (a[WID-1] == b_eff[WID-1]) && (sum[WID-1] != a[WID-1]);
    aux    = a[AUX_BIT] ^ b[AUX_BIT] ^ sum[AUX_BIT];
  end

  // a plain subtraction borrows exactly when the subtrahend is larger
  always_comb begin
    if (!$isunknown({a, b, sub, cin}) && sub && !cin)
      assert_sub_borrow_R3: assert (cb_out == (a < b));
  end

endmodule

// File: rtl/bw_alu_zsp.sv
module bw_alu_zsp #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              word,
  output logic              pf,
  output logic              sf,
  output logic              zf
);

  always_comb begin
    pf = ~^res[LANE_W-1:0];
    sf = word ? res[DATA_W-1] : res[LANE_W-1];
    zf = word ? (res == '0) : (res[LANE_W-1:0] == '0);
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              cf_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] flag_upd_o
);

  localparam int AUX_BIT = LANE_W / 2;
  localparam int N_SIZES = 2;
  localparam logic [DATA_W-1:0] LANE_MSK = DATA_W'({LANE_W{1'b1}});

  logic [DATA_W-1:0] size_msk;
  logic [DATA_W-1:0] a_op, b_op;
  logic              sub_sel, cin_sel;

  logic [DATA_W-1:0] as_sum [N_SIZES];
  logic              as_cb  [N_SIZES];
  logic              as_ovf [N_SIZES];
  logic              as_aux [N_SIZES];

  logic [DATA_W-1:0] sum_sel;
  logic              cb_sel, ovf_sel, aux_sel;
  logic [DATA_W-1:0] res_int;
  logic              is_arith, is_logic;
  logic              pf_w, sf_w, zf_w;
  flags_t            fl_raw;

  assign size_msk = word_i ? '1 : LANE_MSK;

  // operand routing for the shared adder
  always_comb begin
    a_op    = dst_i;
    b_op    = src_i;
    sub_sel = 1'b0;
    cin_sel = 1'b0;
    unique case (op_i)
      OP_ADC:                 cin_sel = cf_i;
      OP_SUB, OP_CMP:         sub_sel = 1'b1;
      OP_SBB: begin           sub_sel = 1'b1; cin_sel = cf_i; end
      OP_NEG: begin           a_op = '0; b_op = dst_i; sub_sel = 1'b1; end
      OP_INC:                 b_op = DATA_W'(1);
      OP_DEC: begin           b_op = DATA_W'(1); sub_sel = 1'b1; end
      default: ;
    endcase
  end

  // one adder per operand size; index 0 = byte, 1 = word
  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int WW = (g == 0) ? LANE_W : DATA_W;
    logic [WW-1:0] s;
    logic          co, ov, ax;

    bw_alu_addsub #(.WID(WW), .AUX_BIT(AUX_BIT)) u_addsub (
      .a      (a_op[WW-1:0]),
      .b      (b_op[WW-1:0]),
      .sub    (sub_sel),
      .cin    (cin_sel),
      .sum    (s),
      .cb_out (co),
      .ovf    (ov),
      .aux    (ax)
    );

    assign as_sum[g] = DATA_W'(s);
    assign as_cb[g]  = co;
    assign as_ovf[g] = ov;
    assign as_aux[g] = ax;
  end

  always_comb begin
    sum_sel = word_i ? as_sum[1] : as_sum[0];
    cb_sel  = word_i ? as_cb[1]  : as_cb[0];
    ovf_sel = word_i ? as_ovf[1] : as_ovf[0];
    aux_sel = word_i ? as_aux[1] : as_aux[0];
  end

  // result, write-enable and update mask per operation
  always_comb begin
    res_int    = '0;
    wr_en_o    = 1'b0;
    flag_upd_o = UPD_NONE;
    is_arith   = 1'b0;
    is_logic   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
        res_int = sum_sel; wr_en_o = 1'b1; flag_upd_o = UPD_ALL; is_arith = 1'b1;
      end
      OP_CMP: begin
        res_int = sum_sel; flag_upd_o = UPD_ALL; is_arith = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_int = sum_sel; wr_en_o = 1'b1; flag_upd_o = UPD_NO_CF; is_arith = 1'b1;
      end
      OP_AND: begin
        res_int = dst_i & src_i; wr_en_o = 1'b1; flag_upd_o = UPD_LOGIC; is_logic = 1'b1;
      end
      OP_OR: begin
        res_int = dst_i | src_i; wr_en_o = 1'b1; flag_upd_o = UPD_LOGIC; is_logic = 1'b1;
      end
      OP_XOR: begin
        res_int = dst_i ^ src_i; wr_en_o = 1'b1; flag_upd_o = UPD_LOGIC; is_logic = 1'b1;
      end
      OP_TEST: begin
        res_int = dst_i & src_i; flag_upd_o = UPD_LOGIC; is_logic = 1'b1;
      end
      OP_NOT: begin
        res_int = ~dst_i; wr_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign res_o = res_int & size_msk;

  bw_alu_zsp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_zsp (
    .res  (res_o),
    .word (word_i),
    .pf   (pf_w),
    .sf   (sf_w),
    .zf   (zf_w)
  );

  always_comb begin
    fl_raw.of = is_arith & ovf_sel;
    fl_raw.sf = sf_w;
    fl_raw.zf = zf_w;
    fl_raw.af = is_arith & aux_sel;
    fl_raw.pf = pf_w;
    fl_raw.cf = is_arith & cb_sel;
    flags_o   = fl_raw & flag_upd_o;
  end

  // checks beside the logic they guard
  always_comb begin
    if (!$isunknown({dst_i, src_i, cf_i, op_i, word_i})) begin
      if (!word_i)
        assert_byte_upper_zero_R1: assert (res_o[DATA_W-1:LANE_W] == '0);
      if (is_logic)
        assert_logic_clears_cf_of_R5: assert (!flags_o[FLG_CF] && !flags_o[FLG_OF]);
      if (op_i == OP_NEG && (dst_i & size_msk) == '0)
        assert_neg_zero_no_carry_R8: assert (!flags_o[FLG_CF] && flags_o[FLG_ZF]);
      if (op_i == OP_INC && (dst_i & size_msk) == size_msk)
        assert_inc_wrap_zero_R9: assert (res_o == '0 && flags_o[FLG_ZF] && !flag_upd_o[FLG_CF]);
    end
  end

endmodule

// File: tb/bw_alu_tb_top.sv
`timescale 1ns/1ps
module bw_alu_tb_top;

  logic        clk = 1'b0;
  logic [15:0] dst, src;
  logic        cf_in;
  logic [3:0]  op;
  logic        word;
  logic [15:0] res;
  logic        wr_en;
  logic [5:0]  flags, upd;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bw_alu dut_i (
    .dst_i(dst), .src_i(src), .cf_i(cf_in), .op_i(op), .word_i(word),
    .res_o(res), .wr_en_o(wr_en), .flags_o(flags), .flag_upd_o(upd)
  );

  // reference: returns {res16, wr, flags6, upd6}
  function automatic logic [28:0] model(input int opc, input logic [15:0] d16,
                                        input logic [15:0] s16, input bit c, input bit w);
    int n   = w ? 16 : 8;
    int m   = (1 << n) - 1;
    int msb = 1 << (n - 1);
    int d   = int'(d16) & m;
    int s   = int'(s16) & m;
    int r = 0, a = 0, b = 0;
    bit cfo = 0, of = 0, af = 0, wr = 0, arith = 0, sub = 0;
    logic [5:0] um = 6'h00;
    logic [15:0] rm;
    logic [5:0] fl;
    case (opc)
      0:  begin a = d; b = s; r = d + s;     cfo = r > m;   wr = 1; um = 6'h3F; arith = 1; end
      1:  begin a = d; b = s; r = d + s + c; cfo = r > m;   wr = 1; um = 6'h3F; arith = 1; end
      2:  begin a = d; b = s; r = d - s;     cfo = d < s;   wr = 1; um = 6'h3F; arith = 1; sub = 1; end
      3:  begin a = d; b = s; r = d - s - c; cfo = d < s + c; wr = 1; um = 6'h3F; arith = 1; sub = 1; end
      4:  begin a = d; b = s; r = d - s;     cfo = d < s;   wr = 0; um = 6'h3F; arith = 1; sub = 1; end
      5:  begin r = d & s; wr = 1; um = 6'h3B; end
      6:  begin r = d | s; wr = 1; um = 6'h3B; end
      7:  begin r = d ^ s; wr = 1; um = 6'h3B; end
      8:  begin r = d & s; wr = 0; um = 6'h3B; end
      9:  begin r = ~d;    wr = 1; um = 6'h00; end
      10: begin a = 0; b = d; r = -d; cfo = d != 0; wr = 1; um = 6'h3F; arith = 1; sub = 1; end
      11: begin a = d; b = 1; r = d + 1; wr = 1; um = 6'h3E; arith = 1; end
      12: begin a = d; b = 1; r = d - 1; wr = 1; um = 6'h3E; arith = 1; sub = 1; end
      default: begin r = 0; wr = 0; um = 6'h00; end
    endcase
    if (arith) begin
      af = ((a ^ b ^ r) & 16) != 0;
      if (sub) of = ((a ^ b) & (a ^ r) & msb) != 0;
      else     of = (~(a ^ b) & (a ^ r) & msb) != 0;
    end
    rm = 16'(r & m);
    fl = {of, (int'(rm) & msb) != 0, rm == 16'h0, af, ~^rm[7:0], cfo} & um;
    return {rm, wr, fl, um};
  endfunction

  function automatic string op_tag(input int opc);
    case (opc)
      0, 1:     return "R2";
      2, 3:     return "R3";
      4:        return "R4";
      5, 6, 7:  return "R5";
      8:        return "R6";
      9:        return "R7";
      10:       return "R8";
      11, 12:   return "R9";
      default:  return "R13";
    endcase
  endfunction

  function automatic string flag_tag(input int bitpos, input int opc);
    case (bitpos)
      1:       return "R10";
      2, 5:    return "R11";
      3, 4:    return "R12";
      default: return op_tag(opc);
    endcase
  endfunction

  task automatic apply(input int opc, input logic [15:0] d, input logic [15:0] s,
                       input bit c, input bit w);
    logic [28:0] e;
    dst = d; src = s; cf_in = c; op = 4'(opc); word = w;
    #1;
    e = model(opc, d, s, c, w);
    n_vec++;
    if (res !== e[28:13]) begin
      n_fail++;
      $display("FAIL %s%s res op=%0d w=%0d d=%h s=%h c=%0d: got %h exp %h",
               w ? "" : "R1,", op_tag(opc), opc, w, d, s, c, res, e[28:13]);
    end
    if (wr_en !== e[12]) begin
      n_fail++;
      $display("FAIL %s wr_en op=%0d: got %b exp %b", op_tag(opc), opc, wr_en, e[12]);
    end
    if (upd !== e[5:0]) begin
      n_fail++;
      $display("FAIL %s mask op=%0d: got %h exp %h", op_tag(opc), opc, upd, e[5:0]);
    end
    // R14: flag bits outside the mask must read zero; model already masks
    for (int k = 0; k < 6; k++) begin
      if (flags[k] !== e[6+k]) begin
        n_fail++;
        $display("FAIL %s flag%0d op=%0d w=%0d d=%h s=%h c=%0d: got %b exp %b",
                 flag_tag(k, opc), k, opc, w, d, s, c, flags[k], e[6+k]);
      end
    end
  endtask

  logic [7:0]  bsrc [16] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h0F, 8'h10, 8'h3F, 8'h40,
                             8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC3, 8'hF0, 8'hFE, 8'hFF};
  logic [15:0] wval [16] = '{16'h0000, 16'h0001, 16'h000F, 16'h00FF, 16'h0100, 16'h0F0F,
                             16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001, 16'h9999, 16'hA5A5,
                             16'hFF00, 16'hFFF0, 16'hFFFE, 16'hFFFF};

  initial begin
    dst = '0; src = '0; cf_in = 0; op = '0; word = 0;
    @(negedge clk);
    // all-zero input vector: ADD byte gives zero, ZF and PF set (R12, R10)
    apply(0, 16'h0000, 16'h0000, 0, 0);
    // R1: byte sweep, every destination against boundary sources, junk upper bytes
    for (int o = 0; o < 16; o++)
      for (int d = 0; d < 256; d++)
        for (int si = 0; si < 16; si++)
          for (int c = 0; c < 2; c++)
            apply(o, {8'(d) ^ 8'h5A, 8'(d)}, {8'hC3, bsrc[si]}, c[0], 0);
    // word sweep over corner values
    for (int o = 0; o < 16; o++)
      for (int di = 0; di < 16; di++)
        for (int si = 0; si < 16; si++)
          for (int c = 0; c < 2; c++)
            apply(o, wval[di], wval[si], c[0], 1);
    // R8 zero operand, R9 wrap, R3 borrow-in chain at word size
    apply(10, 16'h0000, 16'h1234, 1, 1);
    apply(11, 16'hFFFF, 16'h0000, 1, 1);
    apply(12, 16'h0000, 16'h0000, 0, 1);
    apply(3,  16'h0000, 16'hFFFF, 1, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule